// File: doc/BRIEF.md
# Lockable Battery-Backed Register RAM

This block is a small byte-wide register RAM of the kind that holds clock and platform setup values across power cycles. Software reaches it through one synchronous port: an index, write data, a write strobe and a read strobe. Read data appears one clock after the read strobe and stays there until the next read.

Two fixed windows of eight consecutive bytes can be sealed. Each window has its own lock bit, set through a separate configuration write port. Once a window is sealed, writes into it are dropped and reads from it return a filler byte in place of the stored value. Only a hard reset opens the windows again. A separate power-well reset input marks that the backed-up well lost its state by raising a sticky status flag. Software clears that flag with a write-one-to-clear. Neither reset erases the array, so software must rewrite the array itself after it sees the flag.

Top module: `lockram_top`

## Requirements
- R1: Window 0 covers indices WIN0_BASE to WIN0_BASE+7 and window 1 covers WIN1_BASE to WIN1_BASE+7 (defaults 0x38 and 0x48). While unlocked, both windows behave as ordinary RAM.
- R2: A configuration write with cfg_wdata bit 0 set sets lock_sts bit 0 (window 0). A configuration write with bit 1 set sets lock_sts bit 1 (window 1). The new lock bit is visible after that clock edge.
- R3: A configuration write of 0 to a lock bit has no effect. A lock bit, once set, stays set until a hard reset.
- R4: Asserting hard_rst_n low clears both lock bits and clears acc_rdata to 0x00.
- R5: A write strobe to an index inside a locked window leaves the stored byte unchanged.
- R6: A read strobe to an index inside a locked window returns the filler byte (0xFF when FILL_ONES=1, 0x00 otherwise) on acc_rdata one clock later.
- R7: A read strobe loads acc_rdata on the next clock edge. Without a read strobe, acc_rdata holds its value.
- R8: Asserting pwr_rst_n low sets pwr_sts to 1. A hard reset does not change pwr_sts.
- R9: A configuration write with cfg_wdata bit 2 set clears pwr_sts. If pwr_rst_n is low in the same cycle, pwr_sts stays 1.
- R10: Neither reset changes the contents of the array.
- R11: A lock affects only its own eight bytes. The bytes just below and just above a locked window, and the other window while it is unlocked, read and write normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Active-low asynchronous hard reset; clears the lock bits and the read register |
| pwr_rst_n | input | 1 | Active-low asynchronous power-well reset; sets the power-status flag |
| acc_idx | input | IDX_W | Byte index for RAM access |
| acc_wdata | input | 8 | RAM write data |
| acc_wr | input | 1 | RAM write strobe |
| acc_rd | input | 1 | RAM read strobe |
| acc_rdata | output | 8 | Registered RAM read data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration data: bit 0 locks window 0, bit 1 locks window 1, bit 2 clears the power flag |
| lock_sts | output | 2 | Current lock bits, one per window |
| pwr_sts | output | 1 | Sticky power-well reset flag |

## Verification
The bench probes the first and last byte of each window and the bytes just outside it. A decoder that is off by one would then seal a neighbour or leave an edge byte open. It writes zeros into a sealed window and, after a hard reset, reads back the original bytes. A design that let the write through would show zeros there, and one that cleared the array on reset would show lost data. A configuration write of zero after a lock catches lock bits that are plain registers instead of set-only bits. A flag clear issued while the power-well reset is held catches a clear that wrongly takes priority over a new reset event.

// File: rtl/lockram_pkg.sv
package lockram_pkg;
   localparam int unsigned NUM_WIN         = 2;
   localparam int unsigned DATA_W          = 8;
   localparam int unsigned CFG_PWR_CLR_BIT = 2;
   typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/lockram_lockreg.sv
module lockram_lockreg
   import lockram_pkg::*;
(
   input  logic               clk,
   input  logic               hard_rst_n,
   input  logic               pwr_rst_n,
   input  logic               cfg_wr,
   input  byte_t              cfg_wdata,
   output logic [NUM_WIN-1:0] lock_q,
   output logic               pwr_sts
);
   if (CFG_PWR_CLR_BIT < NUM_WIN || CFG_PWR_CLR_BIT >= DATA_W) begin : g_bad_cfg
      $error("lockram_lockreg: clear bit overlaps lock bits or lies outside the byte");
   end

   // set-only lock bits, cleared by the hard reset alone
   always_ff @(posedge clk or negedge hard_rst_n) begin
      if (!hard_rst_n)
         lock_q <= '0;
      else if (cfg_wr)
         lock_q <= lock_q | cfg_wdata[NUM_WIN-1:0];
   end

   // sticky power flag; the asynchronous set beats a same-cycle clear
   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n)
         pwr_sts <= 1'b1;
      else if (cfg_wr && cfg_wdata[CFG_PWR_CLR_BIT])
         pwr_sts <= 1'b0;
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_lock_chk
      AST_LOCK_SET: assert property (@(posedge clk) disable iff (!hard_rst_n)
         (cfg_wr && cfg_wdata[i]) |=> lock_q[i]); // R2
      AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!hard_rst_n)
         lock_q[i] |=> lock_q[i]); // R3
   end

   AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (cfg_wr && cfg_wdata[CFG_PWR_CLR_BIT]) |=> !pwr_sts); // R9
endmodule

// File: rtl/lockram_decode.sv
module lockram_decode
   import lockram_pkg::*;
#(
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned WIN_BYTES = 8,
   parameter int unsigned WIN0_BASE = 56,
   parameter int unsigned WIN1_BASE = 72
) (
   input  logic [IDX_W-1:0]   idx,
   input  logic [NUM_WIN-1:0] lock_q,
   output logic [NUM_WIN-1:0] hit,
   output logic               blocked
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned BASES [NUM_WIN] = '{WIN0_BASE, WIN1_BASE};

   if (WIN0_BASE + WIN_BYTES > DEPTH || WIN1_BASE + WIN_BYTES > DEPTH) begin : g_bad_range
      $error("lockram_decode: a window runs past the end of the array");
   end
   if (WIN0_BASE < WIN1_BASE + WIN_BYTES && WIN1_BASE < WIN0_BASE + WIN_BYTES) begin : g_bad_overlap
      $error("lockram_decode: windows overlap");
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam int unsigned LO = BASES[i];
      localparam int unsigned HI = BASES[i] + WIN_BYTES;
      assign hit[i] = (32'(idx) >= LO) && (32'(idx) < HI);
   end

   assign blocked = |(hit & lock_q);
endmodule

// File: rtl/lockram_array.sv
module lockram_array
   import lockram_pkg::*;
#(
   parameter int unsigned IDX_W     = 7,
   parameter bit          FILL_ONES = 1'b1
) (
   input  logic             clk,
   input  logic             hard_rst_n,
   input  logic [IDX_W-1:0] idx,
   input  byte_t            wdata,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             blocked,
   output byte_t            rdata
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (IDX_W < 4 || IDX_W > 10) begin : g_bad_idx
      $error("lockram_array: IDX_W must be between 4 and 10");
   end

   byte_t fill;
   if (FILL_ONES) begin : g_fill_ones
      assign fill = '1;
   end else begin : g_fill_zeros
      assign fill = '0;
   end

   byte_t mem [DEPTH];

   // contents are kept across both resets
   always_ff @(posedge clk) begin
      if (wr_req && !blocked)
         mem[idx] <= wdata;
   end

   always_ff @(posedge clk or negedge hard_rst_n) begin
      if (!hard_rst_n)
         rdata <= '0;
      else if (rd_req)
         rdata <= blocked ? fill : mem[idx];
   end

   AST_LOCKED_WR_KEEP: assert property (@(posedge clk) disable iff (!hard_rst_n)
      (wr_req && blocked) |=> (mem[$past(idx)] == $past(mem[idx]))); // R5
   AST_LOCKED_RD_FILL: assert property (@(posedge clk) disable iff (!hard_rst_n)
      (rd_req && blocked) |=> (rdata == fill)); // R6
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!hard_rst_n)
      !rd_req |=> $stable(rdata)); // R7
endmodule

// File: rtl/lockram_top.sv
module lockram_top
   import lockram_pkg::*;
#(
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned WIN_BYTES = 8,
   parameter int unsigned WIN0_BASE = 56,
   parameter int unsigned WIN1_BASE = 72,
   parameter bit          FILL_ONES = 1'b1
) (
   input  logic             clk,
   input  logic             hard_rst_n,
   input  logic             pwr_rst_n,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic [7:0]       acc_wdata,
   input  logic             acc_wr,
   input  logic             acc_rd,
   output logic [7:0]       acc_rdata,
   input  logic             cfg_wr,
   input  logic [7:0]       cfg_wdata,
   output logic [1:0]       lock_sts,
   output logic             pwr_sts
);
   logic [NUM_WIN-1:0] lock_q;
   logic [NUM_WIN-1:0] win_hit;
   logic               blocked;

   lockram_lockreg u_lockreg (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .pwr_rst_n  (pwr_rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .lock_q     (lock_q),
      .pwr_sts    (pwr_sts)
   );

   lockram_decode #(
      .IDX_W     (IDX_W),
      .WIN_BYTES (WIN_BYTES),
      .WIN0_BASE (WIN0_BASE),
      .WIN1_BASE (WIN1_BASE)
   ) u_decode (
      .idx     (acc_idx),
      .lock_q  (lock_q),
      .hit     (win_hit),
      .blocked (blocked)
   );

   lockram_array #(
      .IDX_W     (IDX_W),
      .FILL_ONES (FILL_ONES)
   ) u_array (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .idx        (acc_idx),
      .wdata      (acc_wdata),
      .wr_req     (acc_wr),
      .rd_req     (acc_rd),
      .blocked    (blocked),
      .rdata      (acc_rdata)
   );

   assign lock_sts = lock_q;

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!hard_rst_n)
      $onehot0(win_hit)); // R1
   AST_OUTSIDE_OPEN: assert property (@(posedge clk) disable iff (!hard_rst_n)
      (win_hit == '0) |-> !blocked); // R11
   AST_PWR_KEEP_ON_HARD: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (!hard_rst_n && !cfg_wr) |=> $stable(pwr_sts)); // R8
endmodule

// File: tb/lockram_top_test.sv
module lockram_top_test;
   localparam int unsigned IDX_W = 7;

   logic             clk = 1'b0;
   logic             hard_rst_n = 1'b0;
   logic             pwr_rst_n = 1'b0;
   logic [IDX_W-1:0] acc_idx = '0;
   logic [7:0]       acc_wdata = '0;
   logic             acc_wr = 1'b0;
   logic             acc_rd = 1'b0;
   logic [7:0]       acc_rdata;
   logic             cfg_wr = 1'b0;
   logic [7:0]       cfg_wdata = '0;
   logic [1:0]       lock_sts;
   logic             pwr_sts;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lockram_top #(
      .IDX_W(IDX_W), .WIN_BYTES(8), .WIN0_BASE(56), .WIN1_BASE(72), .FILL_ONES(1'b1)
   ) uut (
      .clk(clk), .hard_rst_n(hard_rst_n), .pwr_rst_n(pwr_rst_n),
      .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_wr(acc_wr), .acc_rd(acc_rd),
      .acc_rdata(acc_rdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .lock_sts(lock_sts), .pwr_sts(pwr_sts)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'(i) ^ 8'hA5;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic ram_write(input int i, input logic [7:0] d);
      @(negedge clk);
      acc_idx = IDX_W'(i); acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic ram_read(input int i, output logic [7:0] d);
      @(negedge clk);
      acc_idx = IDX_W'(i); acc_rd = 1'b1;
      @(negedge clk);
      d = acc_rdata;
      acc_rd = 1'b0;
   endtask

   task automatic cfg_write(input logic [7:0] d);
      @(negedge clk);
      cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = '0;
   endtask

   task automatic t_reset;
      repeat (2) @(negedge clk);
      check("R4 locks clear at reset", {6'd0, lock_sts}, 8'h00);
      check("R4 rdata clear at reset", acc_rdata, 8'h00);
      check("R8 pwr flag set", {7'd0, pwr_sts}, 8'h01);
      hard_rst_n = 1'b1; pwr_rst_n = 1'b1;
      @(negedge clk);
      check("R8 pwr flag sticky", {7'd0, pwr_sts}, 8'h01);
   endtask

   task automatic t_pwr_clear;
      cfg_write(8'h04);
      check("R9 pwr flag cleared", {7'd0, pwr_sts}, 8'h00);
      check("R9 clear leaves locks", {6'd0, lock_sts}, 8'h00);
   endtask

   task automatic t_fill_and_readback;
      logic [7:0] d;
      int idxs [10] = '{0, 127, 55, 56, 63, 64, 71, 72, 79, 80};
      for (int i = 0; i < 128; i++) ram_write(i, pat(i));
      foreach (idxs[k]) begin
         ram_read(idxs[k], d);
         check("R1 unlocked readback", d, pat(idxs[k]));
      end
      @(negedge clk);
      acc_idx = 7'd3;
      @(negedge clk);
      check("R7 rdata holds without strobe", acc_rdata, pat(80));
   endtask

   task automatic t_lock_win0;
      logic [7:0] d;
      cfg_write(8'h01);
      check("R2 window 0 lock set", {6'd0, lock_sts}, 8'h01);
      ram_read(56, d); check("R6 locked first byte fill", d, 8'hFF);
      ram_read(63, d); check("R6 locked last byte fill", d, 8'hFF);
      ram_read(55, d); check("R11 byte below window", d, pat(55));
      ram_read(64, d); check("R11 byte above window", d, pat(64));
      ram_read(75, d); check("R11 other window open", d, pat(75));
      ram_write(58, 8'h00);
      ram_write(55, 8'h3C);
      ram_read(55, d); check("R11 neighbour write lands", d, 8'h3C);
      ram_write(76, 8'h5A);
      ram_read(76, d); check("R11 open window write lands", d, 8'h5A);
   endtask

   task automatic t_sticky;
      logic [7:0] d;
      cfg_write(8'h00);
      check("R3 zero write keeps lock", {6'd0, lock_sts}, 8'h01);
      cfg_write(8'h02);
      check("R2 window 1 lock set", {6'd0, lock_sts}, 8'h03);
      ram_read(79, d); check("R6 window 1 fill", d, 8'hFF);
      ram_write(72, 8'h00);
      cfg_write(8'h00);
      check("R3 both locks stay", {6'd0, lock_sts}, 8'h03);
   endtask

   task automatic t_hard_reset;
      logic [7:0] d;
      @(negedge clk); hard_rst_n = 1'b0;
      @(negedge clk); hard_rst_n = 1'b1;
      check("R4 hard reset clears locks", {6'd0, lock_sts}, 8'h00);
      check("R8 hard reset keeps pwr flag", {7'd0, pwr_sts}, 8'h00);
      ram_read(58, d); check("R5 locked write dropped (win0)", d, pat(58));
      ram_read(72, d); check("R5 locked write dropped (win1)", d, pat(72));
      ram_read(100, d); check("R10 hard reset keeps array", d, pat(100));
   endtask

   task automatic t_pwr_race;
      logic [7:0] d;
      @(negedge clk);
      pwr_rst_n = 1'b0; cfg_wr = 1'b1; cfg_wdata = 8'h04;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = '0;
      check("R9 reset beats same-cycle clear", {7'd0, pwr_sts}, 8'h01);
      pwr_rst_n = 1'b1;
      @(negedge clk);
      check("R8 flag stays after release", {7'd0, pwr_sts}, 8'h01);
      ram_read(0, d); check("R10 power reset keeps array", d, pat(0));
   endtask

   initial begin
      t_reset();
      t_pwr_clear();
      t_fill_and_readback();
      t_lock_win0();
      t_sticky();
      t_hard_reset();
      t_pwr_race();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule